// File: doc/BRIEF.md
# Edge-Flagged General-Purpose Port

This block pairs an 8-bit general-purpose I/O port with a small register of four external interrupt flags. Software reaches both through a simple register bus with an address, a write enable, write data, a read strobe and a read-modify-write qualifier. The read data is registered. The eight pins are synchronised through a two-stage flop chain. A normal read of the port address returns those synchronised levels. A read tagged as read-modify-write returns the output latch, so a bit-set or bit-clear sequence never copies a pin that is pulled low back into the latch.

The upper four pins also feed four interrupt channels. Channel k watches pin 4+k and has a fixed edge polarity: the even channels trigger on rising edges and the odd channels on falling edges. An edge sets the channel's flag. Each flag drives its own interrupt request. Software clears a flag by writing zero to it. A hardware set in the same cycle wins over that clear, so no edge is lost.

Top module: `pedge_port`

## Requirements
- R1: After a synchronous reset, `port_latch` is 0xFF, every flag and `irq_req` bit is 0, and `sfr_rdata` is 0. The synchroniser also resets to all ones, which is the idle level of the pins.
- R2: A write to address 0x90 loads `sfr_wdata` into `port_latch` on the same clock edge.
- R3: A read of 0x90 with `sfr_rmw` low returns the pins as seen after two synchronising flops, in bit order (bit n is pin n). `sfr_rdata` is valid one cycle after the strobe and is 0 in any cycle that follows a cycle with no strobe.
- R4: A read of 0x90 with `sfr_rmw` high returns the output latch instead of the pins.
- R5: A read of 0x91 returns the flag for channel k in bit 4+k, with bits 3:0 reading 0. Writes to bits 3:0 have no effect.
- R6: The flags of channel 0 (pin 4) and channel 2 (pin 6) set on a rising edge of the synchronised pin. The flag shows two clocks after the edge that samples the new pin level.
- R7: The flags of channel 1 (pin 5) and channel 3 (pin 7) set on a falling edge, with the same latency as in R6.
- R8: A write to 0x91 loads bits 7:4 into the flags, so a zero clears a flag. A flag holds its value while it sees no write and no edge.
- R9: When a hardware set and a software clear of the same flag fall in the same cycle, the flag ends up set.
- R10: `irq_req[k]` always equals flag k.
- R11: Reads of any address other than 0x90 and 0x91 return 0. Writes to such addresses change neither the latch nor the flags.
- R12: Activity on pins 0 to 3 never sets a flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sfr_addr | input | 8 | Register address |
| sfr_we | input | 1 | Write enable |
| sfr_wdata | input | 8 | Write data |
| sfr_re | input | 1 | Read strobe |
| sfr_rmw | input | 1 | Marks the read as part of a read-modify-write |
| sfr_rdata | output | 8 | Registered read data |
| pin_in | input | 8 | Asynchronous pin levels |
| port_latch | output | 8 | Output latch value |
| irq_req | output | 4 | One interrupt request per flag |

## Verification
The bench builds the block with its default parameters: an 8-bit port, two synchroniser stages, four channels starting at pin 4, and the port and flag registers at 0x90 and 0x91. With only four channels, every polarity can be driven through both edge directions in a short directed sequence. The shallow synchroniser lets the bench line up a flag-clear write exactly with the cycle in which an edge is detected, which is the collision that R9 covers. A long stretch of random pin, read and write traffic then checks every output against a behavioural model on every clock.

// File: rtl/pedge_pkg.sv
package pedge_pkg;
  // Channel k of the interrupt bank observes pin (base + k); odd channels
  // react to falling edges, even channels to rising edges.
  function automatic logic ch_is_falling(input int k);
    return (k % 2) == 1;
  endfunction

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_PINS = 2'd1,
    SEL_LATCH = 2'd2,
    SEL_FLAGS = 2'd3
  } rd_sel_e;
endpackage

// File: rtl/pedge_sync.sv
module pedge_sync #(
  parameter int W = 8,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/pedge_flag_bank.sv
module pedge_flag_bank #(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] ch_in,
  input  logic              wr_en,
  input  logic [NUM_CH-1:0] wr_val,
  output logic [NUM_CH-1:0] flags,
  output logic [NUM_CH-1:0] edge_set
);
  import pedge_pkg::*;

  logic [NUM_CH-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '1;
    else     prev_q <= ch_in;
  end

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    if (ch_is_falling(k)) begin : g_fall
      assign edge_set[k] = prev_q[k] & ~ch_in[k];
    end else begin : g_rise
      assign edge_set[k] = ~prev_q[k] & ch_in[k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) flags <= '0;
    else     flags <= (wr_en ? wr_val : flags) | edge_set;
  end
endmodule

// File: rtl/pedge_read_mux.sv
module pedge_read_mux #(
  parameter int DATA_W = 8,
  parameter int NUM_CH = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  pedge_pkg::rd_sel_e  sel,
  input  logic [DATA_W-1:0]   pins,
  input  logic [DATA_W-1:0]   latch,
  input  logic [NUM_CH-1:0]   flags,
  output logic [DATA_W-1:0]   rdata
);
  import pedge_pkg::*;

  localparam int PAD_W = DATA_W - NUM_CH;

  logic [DATA_W-1:0] mux_d;

  always_comb begin
    unique case (sel)
      SEL_PINS:  mux_d = pins;
      SEL_LATCH: mux_d = latch;
      SEL_FLAGS: mux_d = {flags, {PAD_W{1'b0}}};
      default:   mux_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= mux_d;
  end
endmodule

// File: rtl/pedge_port.sv
module pedge_port #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 8'h90,
  parameter logic [ADDR_W-1:0] FLAG_ADDR = 8'h91,
  parameter int SYNC_STAGES = 2,
  parameter int NUM_CH = 4,
  parameter int CH_PIN_BASE = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] sfr_addr,
  input  logic              sfr_we,
  input  logic [DATA_W-1:0] sfr_wdata,
  input  logic              sfr_re,
  input  logic              sfr_rmw,
  output logic [DATA_W-1:0] sfr_rdata,
  input  logic [DATA_W-1:0] pin_in,
  output logic [DATA_W-1:0] port_latch,
  output logic [NUM_CH-1:0] irq_req
);
  import pedge_pkg::*;

  localparam int FLAG_LSB = DATA_W - NUM_CH;

  logic [DATA_W-1:0] pins_sync;
  logic [NUM_CH-1:0] flags;
  logic [NUM_CH-1:0] edge_set;
  logic              hit_port;
  logic              hit_flag;
  rd_sel_e           rd_sel;

  assign hit_port = (sfr_addr == PORT_ADDR);
  assign hit_flag = (sfr_addr == FLAG_ADDR);

  pedge_sync #(.W(DATA_W), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
    .clk(clk), .rst(rst), .d(pin_in), .q(pins_sync)
  );

  always_ff @(posedge clk) begin
    if (rst) port_latch <= '1;
    else if (sfr_we && hit_port) port_latch <= sfr_wdata;
  end

  pedge_flag_bank #(.NUM_CH(NUM_CH)) u_flags (
    .clk(clk), .rst(rst),
    .ch_in(pins_sync[CH_PIN_BASE +: NUM_CH]),
    .wr_en(sfr_we && hit_flag),
    .wr_val(sfr_wdata[FLAG_LSB +: NUM_CH]),
    .flags(flags),
    .edge_set(edge_set)
  );

  always_comb begin
    if (!sfr_re)       rd_sel = SEL_NONE;
    else if (hit_port) rd_sel = sfr_rmw ? SEL_LATCH : SEL_PINS;
    else if (hit_flag) rd_sel = SEL_FLAGS;
    else               rd_sel = SEL_NONE;
  end

  pedge_read_mux #(.DATA_W(DATA_W), .NUM_CH(NUM_CH)) u_rd (
    .clk(clk), .rst(rst), .sel(rd_sel),
    .pins(pins_sync), .latch(port_latch), .flags(flags),
    .rdata(sfr_rdata)
  );

  assign irq_req = flags;
endmodule

// File: rtl/pedge_port_chk.sv
module pedge_port_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 8'h90,
  parameter logic [ADDR_W-1:0] FLAG_ADDR = 8'h91,
  parameter int NUM_CH = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] sfr_addr,
  input logic              sfr_we,
  input logic [DATA_W-1:0] sfr_wdata,
  input logic              sfr_re,
  input logic              sfr_rmw,
  input logic [DATA_W-1:0] sfr_rdata,
  input logic [DATA_W-1:0] port_latch,
  input logic [NUM_CH-1:0] irq_req,
  input logic [NUM_CH-1:0] edge_set
);
  localparam int FLAG_LSB = DATA_W - NUM_CH;

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (port_latch == '1 && irq_req == '0 && sfr_rdata == '0));

  assert_latch_load_R2: assert property (@(posedge clk) disable iff (rst)
    ($past(sfr_we) && $past(sfr_addr) == PORT_ADDR) |-> port_latch == $past(sfr_wdata));

  assert_idle_read_zero_R3: assert property (@(posedge clk) disable iff (rst)
    !$past(sfr_re) |-> sfr_rdata == '0);

  assert_rmw_latch_R4: assert property (@(posedge clk) disable iff (rst)
    ($past(sfr_re) && $past(sfr_rmw) && $past(sfr_addr) == PORT_ADDR)
      |-> sfr_rdata == $past(port_latch));

  assert_flag_pad_zero_R5: assert property (@(posedge clk) disable iff (rst)
    ($past(sfr_re) && $past(sfr_addr) == FLAG_ADDR) |-> sfr_rdata[FLAG_LSB-1:0] == '0);

  assert_flag_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!($past(sfr_we) && $past(sfr_addr) == FLAG_ADDR) && $past(edge_set) == '0)
      |-> $stable(irq_req));

  assert_set_wins_R9: assert property (@(posedge clk) disable iff (rst)
    (|$past(edge_set)) |-> ((irq_req & $past(edge_set)) == $past(edge_set)));

  assert_other_addr_R11: assert property (@(posedge clk) disable iff (rst)
    ($past(sfr_re) && $past(sfr_addr) != PORT_ADDR && $past(sfr_addr) != FLAG_ADDR)
      |-> sfr_rdata == '0);
endmodule

bind pedge_port pedge_port_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .PORT_ADDR(PORT_ADDR),
  .FLAG_ADDR(FLAG_ADDR), .NUM_CH(NUM_CH)
) u_chk (
  .clk(clk), .rst(rst), .sfr_addr(sfr_addr), .sfr_we(sfr_we),
  .sfr_wdata(sfr_wdata), .sfr_re(sfr_re), .sfr_rmw(sfr_rmw),
  .sfr_rdata(sfr_rdata), .port_latch(port_latch), .irq_req(irq_req),
  .edge_set(edge_set)
);

// File: tb/pedge_port_test.sv
`timescale 1ns/1ps
module pedge_port_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] sfr_addr = 8'h00;
  logic       sfr_we = 1'b0;
  logic [7:0] sfr_wdata = 8'h00;
  logic       sfr_re = 1'b0;
  logic       sfr_rmw = 1'b0;
  logic [7:0] sfr_rdata;
  logic [7:0] pin_in = 8'hFF;
  logic [7:0] port_latch;
  logic [3:0] irq_req;

  int n_chk = 0;
  int n_bad = 0;
  string cur_req = "R1";
  bit started = 0;

  always #2 clk = ~clk;

  pedge_port uut (
    .clk(clk), .rst(rst), .sfr_addr(sfr_addr), .sfr_we(sfr_we),
    .sfr_wdata(sfr_wdata), .sfr_re(sfr_re), .sfr_rmw(sfr_rmw),
    .sfr_rdata(sfr_rdata), .pin_in(pin_in), .port_latch(port_latch),
    .irq_req(irq_req)
  );

  // Behavioural reference model
  int m_s1, m_s2, m_prev, m_latch, m_flags, m_rdata;

  always @(posedge clk) begin
    int rise, fall, setm, rd;
    started = 1;
    if (rst) begin
      m_s1 = 255; m_s2 = 255; m_prev = 255;
      m_latch = 255; m_flags = 0; m_rdata = 0;
    end else begin
      rd = 0;
      if (sfr_re) begin
        if (sfr_addr == 8'h90) rd = sfr_rmw ? m_latch : m_s2;
        else if (sfr_addr == 8'h91) rd = m_flags * 16;
      end
      rise = m_s2 & ~m_prev & 255;
      fall = m_prev & ~m_s2 & 255;
      setm = 0;
      if (rise & 16)  setm |= 1;
      if (fall & 32)  setm |= 2;
      if (rise & 64)  setm |= 4;
      if (fall & 128) setm |= 8;
      if (sfr_we && sfr_addr == 8'h91) m_flags = (sfr_wdata >> 4) & 15;
      m_flags |= setm;
      if (sfr_we && sfr_addr == 8'h90) m_latch = sfr_wdata;
      m_prev = m_s2; m_s2 = m_s1; m_s1 = pin_in;
      m_rdata = rd;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      check({cur_req, " rdata"}, int'(sfr_rdata), m_rdata);
      check({cur_req, " latch"}, int'(port_latch), m_latch);
      check({"R10 irq/", cur_req}, int'(irq_req), m_flags);
    end
  end

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    sfr_addr = a; sfr_wdata = d; sfr_we = 1'b1;
    tick();
    sfr_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic rmw, output logic [7:0] d);
    sfr_addr = a; sfr_rmw = rmw; sfr_re = 1'b1;
    tick();
    d = sfr_rdata;
    sfr_re = 1'b0; sfr_rmw = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    tick(3);
    rst = 1'b0;
    tick();
    check("R1 latch", port_latch, 8'hFF);
    check("R1 irq", irq_req, 0);
    check("R1 rdata", sfr_rdata, 0);

    cur_req = "R2";
    wr(8'h90, 8'hA5);
    check("R2 latch", port_latch, 8'hA5);
    wr(8'h90, 8'h3C);
    check("R2 latch", port_latch, 8'h3C);

    cur_req = "R3";
    pin_in = 8'hC3;
    tick(3);
    rd(8'h90, 1'b0, d);
    check("R3 pin read", d, 8'hC3);
    tick();
    check("R3 idle rdata", sfr_rdata, 0);
    check("R7 ch1 falling", irq_req, 4'b0010);

    cur_req = "R4";
    rd(8'h90, 1'b1, d);
    check("R4 rmw read", d, 8'h3C);

    cur_req = "R5";
    rd(8'h91, 1'b0, d);
    check("R5 flag read", d, 8'h20);
    wr(8'h91, 8'h0F);
    rd(8'h91, 1'b0, d);
    check("R5 low bits ignored", d, 8'h00);
    check("R8 cleared", irq_req, 0);

    cur_req = "R6";
    pin_in = 8'hD3; tick(3);
    check("R6 ch0 rising", irq_req, 4'b0001);
    pin_in = 8'hF3; tick(3);
    check("R7 ch1 no set on rise", irq_req, 4'b0001);
    pin_in = 8'hB3; tick(3);
    check("R6 ch2 no set on fall", irq_req, 4'b0001);
    pin_in = 8'hF3; tick(3);
    check("R6 ch2 rising", irq_req, 4'b0101);
    cur_req = "R7";
    pin_in = 8'h73; tick(3);
    check("R7 ch3 falling", irq_req, 4'b1101);

    cur_req = "R12";
    wr(8'h91, 8'h00);
    for (int i = 0; i < 6; i++) begin
      pin_in = pin_in ^ 8'h0F; tick(2);
    end
    tick(2);
    check("R12 low pins", irq_req, 0);

    cur_req = "R9";
    pin_in = 8'h63; tick(4);
    wr(8'h91, 8'h00);
    pin_in = 8'h73; tick(2);
    wr(8'h91, 8'h00);
    check("R9 set wins", irq_req, 4'b0001);

    cur_req = "R11";
    wr(8'h92, 8'h00);
    check("R11 latch kept", port_latch, 8'h3C);
    check("R11 flags kept", irq_req, 4'b0001);
    rd(8'h92, 1'b0, d);
    check("R11 other read", d, 0);

    cur_req = "R10";
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r;
      r = $urandom;
      pin_in = r[7:0];
      sfr_addr = r[8] ? 8'h90 : (r[9] ? 8'h91 : 8'h93);
      sfr_we = (r[12:10] == 3'd0);
      sfr_wdata = r[23:16];
      sfr_re = r[13];
      sfr_rmw = r[14];
      tick();
    end
    sfr_we = 1'b0; sfr_re = 1'b0;
    tick(2);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule